// File: doc/BRIEF.md
# GPIO Edge Interrupt Bank

This block is a bank of general-purpose I/O lines grouped into byte-wide ports (four ports of eight lines by default, 32 lines in all). Software reaches it through a simple word-wide register port that completes a write in one clock and returns read data combinationally. It sets the output enable and output value of each line, and reads back the line levels. It also selects, per line, which edges of the input raise an interrupt.

Every input passes through a two-stage synchroniser. An edge detector follows it and sets a sticky pending bit. Software clears that bit by writing a one to it. Each CPU has its own routing mask word, and each CPU gets its own interrupt output, driven from a register. A static strap input selects one of two layouts. In native layout, register bit L is line L. In swapped layout, the four port bytes appear in reverse order on the bus, and the two-bit edge-select fields are placed in exchanged port pairs.

Top module: `gpio_edge_irq_bank`

Register word index (byte address divided by 4; accesses with the low two address bits nonzero have no effect and read 0): 0 output enable, 1 data, 2 pending status, 3 and 4 edge-select words (64 bits, word 3 holds bits 0..31), 8 + c routing mask of CPU c.

## Requirements
- R1: After reset every register is zero. All lines are inputs (`gpio_oe` = 0), `gpio_out` = 0, no status bit is pending, and every `cpu_irq` is low.
- R2: With `swap_order` = 0, bus bit L of the output-enable and data words maps to line L. Writes reach `gpio_oe` and `gpio_out` after the write edge, and the output-enable word reads back as written.
- R3: With `swap_order` = 1, the output-enable, data, status and routing words are byte-reversed on the bus. Line L sits at bus bit 8*(3 - L/8) + L%8. The edge-select words are never byte-reversed.
- R4: With `swap_order` = 0, the two-bit edge-select field of line L occupies bits 2L+1:2L of the 64-bit edge-select value. Bits 32 and above sit in word 4 at bit position minus 32.
- R5: With `swap_order` = 1, the field of line L starts at bit 2*(8*((L/8) XOR 1) + L%8) of the 64-bit edge-select value.
- R6: Field bit 0 enables falling-edge detection and field bit 1 enables rising-edge detection. The value 11 enables both, and 00 lets no edge set the status bit.
- R7: An input change applied between clock edges sets its status bit at the third following rising edge. The bit stays clear after the first two.
- R8: Writing the status word clears each status bit written as 1. Bits written as 0 keep their value.
- R9: When an edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: `cpu_irq[c]` is registered. It equals the OR over all lines of (status AND CPU c's routing mask) one cycle later.
- R11: The routing mask of CPU c is the word at index 8 + c. A pending line drives only the CPUs whose mask has that line's bit set.
- R12: Reading the data word returns the output value for lines with output enable set, and the synchronised input level for the other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| swap_order | input | 1 | Layout strap: 0 native, 1 swapped port and byte order |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_in | input | 32 | Line input levels, asynchronous |
| gpio_out | output | 32 | Line output values |
| gpio_oe | output | 32 | Line output enables, 1 = drive |
| cpu_irq | output | 2 | Per-CPU interrupt request |

## Verification
Register writes show on `gpio_oe`, `gpio_out` and the read port from the cycle after the write edge. A pin change needs three rising edges before its status bit reads as set, and a fourth before the matching `cpu_irq` rises. The bench drives all inputs just after a rising edge. It queues each expected value for the cycle in which it is due and compares it at the following falling edge. For the edge timing, it also queues a clear expectation one cycle early, to pin down the exact edge. The same-cycle collision of an edge with a clearing write is produced by timing the write to cover exactly the third edge after the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // register word indices (byte address / 4)
  localparam int IDX_DIR   = 0;
  localparam int IDX_DATA  = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_MODE  = 3;
  localparam int IDX_ROUTE = 8;

  localparam int MODE_BITS = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DATA,
    SEL_STAT,
    SEL_MODE,
    SEL_ROUTE
  } reg_sel_e;

endpackage

// File: rtl/gpio_port_swap.sv
module gpio_port_swap #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic                          en,
  input  logic [NUM_PORTS*PORT_W-1:0]   din,
  output logic [NUM_PORTS*PORT_W-1:0]   dout
);

  // reverse the order of the port slices when enabled
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign dout[p*PORT_W +: PORT_W] =
      en ? din[(NUM_PORTS-1-p)*PORT_W +: PORT_W] : din[p*PORT_W +: PORT_W];
  end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              swap_order,
  input  logic [NUM_PORTS*PORT_W-1:0]       pins,
  input  logic [2*NUM_PORTS*PORT_W-1:0]     mode_flat,
  output logic [NUM_PORTS*PORT_W-1:0]       sync_val,
  output logic [NUM_PORTS*PORT_W-1:0]       edge_ev
);

  localparam int LINES = NUM_PORTS * PORT_W;

  logic [LINES-1:0] s1_q, s2_q, prev_q;
  logic [LINES-1:0] s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = pins;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign sync_val = s2_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam int POS_NAT = 2 * i;
    localparam int POS_SWP = 2 * (PORT_W * ((i / PORT_W) ^ 1) + (i % PORT_W));
    logic [1:0] fld;
    logic       rise, fall;
    assign fld  = swap_order ? mode_flat[POS_SWP +: 2] : mode_flat[POS_NAT +: 2];
    assign rise = s2_q[i] & ~prev_q[i];
    assign fall = ~s2_q[i] & prev_q[i];
    assign edge_ev[i] = (fld[1] & rise) | (fld[0] & fall);
  end

endmodule

// File: rtl/gpio_status_reg.sv
module gpio_status_reg #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_vec,
  input  logic [LINES-1:0] clr_vec,
  output logic [LINES-1:0] status
);

  logic [LINES-1:0] status_q, status_d;

  // a new edge outranks a clearing write on the same bit
  always_comb begin
    status_d = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(set_vec | clr_vec)) ==
              ($past(status_q) & ~$past(set_vec | clr_vec))));

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int LINES    = 32,
  parameter int NUM_CPUS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LINES-1:0]          status,
  input  logic [NUM_CPUS*LINES-1:0] mask_flat,
  output logic [NUM_CPUS-1:0]       cpu_irq
);

  logic [NUM_CPUS-1:0] irq_d, irq_q;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign irq_d[c] = |(status & mask_flat[c*LINES +: LINES]);

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_q[c] == |($past(status) & $past(mask_flat[c*LINES +: LINES]))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign cpu_irq = irq_q;

endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          swap_order,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_PORTS*PORT_W-1:0]   bus_wdata,
  output logic [NUM_PORTS*PORT_W-1:0]   bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   gpio_in,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_out,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_oe,
  output logic [NUM_CPUS-1:0]           cpu_irq
);

  localparam int LINES      = NUM_PORTS * PORT_W;
  localparam int MODE_WORDS = MODE_BITS;
  localparam int WIDX_W     = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_DIR   = WIDX_W'(IDX_DIR);
  localparam logic [WIDX_W-1:0] W_DATA  = WIDX_W'(IDX_DATA);
  localparam logic [WIDX_W-1:0] W_STAT  = WIDX_W'(IDX_STAT);
  localparam logic [WIDX_W-1:0] W_MODE  = WIDX_W'(IDX_MODE);
  localparam logic [WIDX_W-1:0] W_MEND  = WIDX_W'(IDX_MODE + MODE_WORDS);
  localparam logic [WIDX_W-1:0] W_ROUTE = WIDX_W'(IDX_ROUTE);
  localparam logic [WIDX_W-1:0] W_REND  = WIDX_W'(IDX_ROUTE + NUM_CPUS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // address decode
  logic [WIDX_W-1:0] word_idx;
  reg_sel_e          sel;
  int unsigned       sub;

  assign word_idx = bus_addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    sub = 0;
    if (bus_addr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else if (word_idx == W_DIR) begin
      sel = SEL_DIR;
    end else if (word_idx == W_DATA) begin
      sel = SEL_DATA;
    end else if (word_idx == W_STAT) begin
      sel = SEL_STAT;
    end else if (word_idx >= W_MODE && word_idx < W_MEND) begin
      sel = SEL_MODE;
      sub = 32'(word_idx - W_MODE);
    end else if (word_idx >= W_ROUTE && word_idx < W_REND) begin
      sel = SEL_ROUTE;
      sub = 32'(word_idx - W_ROUTE);
    end
  end

  // bus to internal line order
  logic [LINES-1:0] wdata_int;

  gpio_port_swap #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_wswap (
    .en   (swap_order),
    .din  (bus_wdata),
    .dout (wdata_int)
  );

  // register state
  logic [LINES-1:0]            dir_q, dir_d;
  logic [LINES-1:0]            out_q, out_d;
  logic [MODE_WORDS*LINES-1:0] mode_q, mode_d;
  logic [NUM_CPUS*LINES-1:0]   mask_q, mask_d;
  logic [LINES-1:0]            clr_vec;

  always_comb begin
    dir_d   = dir_q;
    out_d   = out_q;
    mode_d  = mode_q;
    mask_d  = mask_q;
    clr_vec = '0;
    if (bus_wr) begin
      case (sel)
        SEL_DIR:   dir_d = wdata_int;
        SEL_DATA:  out_d = wdata_int;
        SEL_STAT:  clr_vec = wdata_int;
        SEL_MODE:  mode_d[sub*LINES +: LINES] = bus_wdata;
        SEL_ROUTE: mask_d[sub*LINES +: LINES] = wdata_int;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dir_q  <= '0;
      out_q  <= '0;
      mode_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      mode_q <= mode_d;
      mask_q <= mask_d;
    end
  end

  assign gpio_out = out_q;
  assign gpio_oe  = dir_q;

  // edge detection, status, routing
  logic [LINES-1:0] sync_val, edge_ev, status;

  gpio_edge_detect #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .swap_order (swap_order),
    .pins       (gpio_in),
    .mode_flat  (mode_q),
    .sync_val   (sync_val),
    .edge_ev    (edge_ev)
  );

  gpio_status_reg #(.LINES(LINES)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_vec (edge_ev),
    .clr_vec (clr_vec),
    .status  (status)
  );

  gpio_irq_route #(.LINES(LINES), .NUM_CPUS(NUM_CPUS)) u_route (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .status    (status),
    .mask_flat (mask_q),
    .cpu_irq   (cpu_irq)
  );

  // read path
  logic [LINES-1:0] rd_raw;
  logic             rd_swap;

  always_comb begin
    rd_raw = '0;
    case (sel)
      SEL_DIR:   rd_raw = dir_q;
      SEL_DATA:  rd_raw = (out_q & dir_q) | (sync_val & ~dir_q);
      SEL_STAT:  rd_raw = status;
      SEL_MODE:  rd_raw = mode_q[sub*LINES +: LINES];
      SEL_ROUTE: rd_raw = mask_q[sub*LINES +: LINES];
      default:   rd_raw = '0;
    endcase
  end

  assign rd_swap = swap_order & (sel != SEL_MODE);

  gpio_port_swap #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_rswap (
    .en   (rd_swap),
    .din  (rd_raw),
    .dout (bus_rdata)
  );

  p_oe_tracks_write_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && sel == SEL_DIR) |=> (gpio_oe == $past(wdata_int)));

  p_no_irq_in_reset_r1: assert property (@(posedge clk)
    (!rst_n_s) |=> (status == '0 || !rst_n_s));

endmodule

// File: tb/sim_gpio_edge_irq_bank.sv
module sim_gpio_edge_irq_bank;

  localparam logic [5:0] A_DIR = 6'd0, A_DATA = 6'd4, A_STAT = 6'd8;
  localparam logic [5:0] A_MODE0 = 6'd12, A_MODE1 = 6'd16;
  localparam logic [5:0] A_ROUTE0 = 6'd32, A_ROUTE1 = 6'd36;
  localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_IRQ = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_order = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] gpio_in = '0;
  logic [31:0] gpio_out, gpio_oe;
  logic [1:0]  cpu_irq;

  gpio_edge_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .swap_order(swap_order),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .cpu_irq(cpu_irq)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t       it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_OE:    act = gpio_oe;
        K_OUT:   act = gpio_out;
        default: act = {30'd0, cpu_irq};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_wr = 1'b0;
  endtask

  task automatic expect_pin(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    expect_pin(K_RD, e, tag);
    cyc(1);
  endtask

  task automatic do_reset(input logic sw);
    rst_n = 1'b0; swap_order = sw; gpio_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    do_reset(1'b0);
    // R1 reset state
    expect_pin(K_OE, 32'h0, "R1 oe");
    expect_pin(K_OUT, 32'h0, "R1 out");
    expect_pin(K_IRQ, 32'h0, "R1 irq");
    expect_rd(A_STAT, 32'h0, "R1 status");
    expect_rd(A_MODE1, 32'h0, "R1 mode");

    // R2 native direction/data
    wr(A_DIR, 32'h0000_00FF);
    wr(A_DATA, 32'h0000_00A5);
    expect_pin(K_OE, 32'h0000_00FF, "R2 oe");
    expect_pin(K_OUT, 32'h0000_00A5, "R2 out");
    expect_rd(A_DIR, 32'h0000_00FF, "R2 dir readback");

    // R12 data readback mixes outputs and synced inputs; R6 disabled lines stay quiet
    gpio_in = 32'h0000_1200;
    cyc(4);
    expect_rd(A_DATA, 32'h0000_12A5, "R12 data read");
    expect_rd(A_STAT, 32'h0, "R6 mode 00 no status");

    // R4 native line 3 rising (field at bit 6), routed to cpu0 (R11)
    wr(A_MODE0, 32'h0000_0080);
    wr(A_ROUTE0, 32'h0000_0008);
    gpio_in[3] = 1'b1;
    cyc(2);
    expect_rd(A_STAT, 32'h0, "R7 not yet after two edges");
    expect_pin(K_IRQ, 32'h0, "R10 irq not before register");
    expect_rd(A_STAT, 32'h0000_0008, "R7 set at third edge");
    expect_pin(K_IRQ, 32'h1, "R10 cpu0 irq");

    // R8 write-one-to-clear
    wr(A_STAT, 32'h0);
    expect_rd(A_STAT, 32'h0000_0008, "R8 zero write keeps");
    wr(A_STAT, 32'h0000_0008);
    expect_pin(K_RD, 32'h0, "R8 cleared");
    cyc(1);
    expect_pin(K_IRQ, 32'h0, "R10 irq drops");

    // R6 falling edge ignored when only rising enabled
    gpio_in[3] = 1'b0;
    cyc(4);
    expect_rd(A_STAT, 32'h0, "R6 falling ignored");

    // R9 set wins over same-cycle clear
    gpio_in[3] = 1'b1;
    cyc(2);
    wr(A_STAT, 32'h0000_0008);
    expect_rd(A_STAT, 32'h0000_0008, "R9 set wins");
    wr(A_STAT, 32'h0000_0008);
    expect_rd(A_STAT, 32'h0, "R8 clear after collision");

    // R4 native line 20 falling, field in second word bit 8; R11 routing per cpu
    gpio_in[20] = 1'b1;
    cyc(4);
    wr(A_MODE1, 32'h0000_0100);
    gpio_in[20] = 1'b0;
    cyc(3);
    expect_rd(A_STAT, 32'h0010_0000, "R4 second word field");
    expect_pin(K_IRQ, 32'h0, "R11 unrouted line");
    wr(A_ROUTE1, 32'h0010_0000);
    cyc(1);
    expect_pin(K_IRQ, 32'h2, "R11 cpu1 only");
    wr(A_STAT, 32'h0010_0000);

    // R6 both edges on line 5 (field at bit 10)
    wr(A_MODE0, 32'h0000_0C80);
    gpio_in[5] = 1'b1;
    cyc(3);
    expect_rd(A_STAT, 32'h0000_0020, "R6 both rise");
    wr(A_STAT, 32'h0000_0020);
    gpio_in[5] = 1'b0;
    cyc(3);
    expect_rd(A_STAT, 32'h0000_0020, "R6 both fall");

    // swapped layout
    do_reset(1'b1);
    expect_pin(K_OE, 32'h0, "R1 swap reset oe");
    wr(A_DIR, 32'h0000_00FF);
    expect_pin(K_OE, bsw(32'h0000_00FF), "R3 oe byte reversed");
    expect_rd(A_DIR, 32'h0000_00FF, "R3 dir readback");

    // R5 line 8 -> field pos 0 rising; line 0 -> pos 16 both
    wr(A_MODE0, 32'h0003_0002);
    expect_rd(A_MODE0, 32'h0003_0002, "R3 mode word not reversed");
    wr(A_ROUTE1, bsw(32'h0000_0100));
    gpio_in[8] = 1'b1;
    cyc(3);
    expect_rd(A_STAT, bsw(32'h0000_0100), "R5 swapped field line 8");
    expect_pin(K_IRQ, 32'h2, "R11 swapped route cpu1");
    gpio_in[0] = 1'b1;
    cyc(3);
    expect_rd(A_STAT, bsw(32'h0000_0101), "R5 swapped field line 0");
    gpio_in[16] = 1'b1;
    cyc(4);
    expect_rd(A_STAT, bsw(32'h0000_0101), "R5 line 16 disabled");

    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule